// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block models the command side of a parallel NOR flash as synthesizable logic. Host bus writes pass through a multi-step decoder that recognises unlock pairs, program and erase setup codes, a shortcut programming mode, erase pause and continue, and a software reset code. Accepted operations run for a parameterised number of clock cycles against a small register-based cell array. While an operation runs, reads return a status word rather than array data, and a ready/busy pin is held low.

The array has `2**ADDR_W` words split into `2**SECT_W` equal sectors, where the sector number is the top address bits. Commands are carried in the low byte of the write data. The two highest-numbered sectors are the boot sectors, and a write-protect pin can lock them. An active-low abort input stops any operation and leaves the array contents as they are at that point. `rst_ni` is the power-on reset and fills the array with ones.

Top module: `nor_cmd_fsm`

## Requirements
- R1: After power-on reset, ry_by_o is 1 and every word reads as all ones.
- R2: A program runs on the writes AA@UNLK_A, 55@UNLK_B, A0@UNLK_A and then data@target. The stored word becomes the old word ANDed with the data.
- R3: The writes AA@UNLK_A, 55@UNLK_B, 20@UNLK_A enter the shortcut mode. In this mode, A0 at any address followed by data@target programs the word. The writes 90 and then 00 leave the mode, and after that a bare A0 and data pair has no effect.
- R4: While busy, bit 7 of a read is the inverse of bit 7 of the data being programmed. During an erase this bit reads 0.
- R5: While busy, bit 6 of a read flips on every read, and every status bit other than 7, 6 and 5 reads 0. rdata_o changes only on a read.
- R6: ry_by_o goes low only on a bus write that starts or resumes an operation. It stays low for PROG_CYC cycles for a program and PRE_CYC+ERASE_CYC cycles for an erase.
- R7: hw_reset_ni low aborts any operation. ry_by_o is 1 at the next clock, a program that was aborted leaves its word unchanged, and the decoder is back in array-read state.
- R8: The writes AA, 55, 80, AA, 55 to the unlock addresses, followed by 30 at an address inside a sector, erase that sector to all ones and leave all other sectors untouched. Ending the sequence with 10@UNLK_A instead erases every unprotected sector.
- R9: An erase first clears every word of the selected sectors to 0 after PRE_CYC cycles, and only then sets them to all ones.
- R10: The code B0 during an erase pauses it and sets ry_by_o to 1 at once. While paused, other sectors can be read and programmed, and a program into the sector being erased is ignored. The code 30 continues the erase for the cycles that remain.
- R11: With wp_ni low, a program or erase that targets sector 2**SECT_W-1 or 2**SECT_W-2 is ignored, and so is one that targets any sector whose sect_lock_i bit is 1. ry_by_o stays 1 and the data is unchanged.
- R12: A write with the wrong address or data at any unlock step drops the sequence back to array read with no effect.
- R13: A program that would turn a 0 bit into 1 leaves the word unchanged. After PROG_CYC cycles status bit 5 reads 1, and ry_by_o stays low until the code F0 is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| hw_reset_ni | input | 1 | Operation abort, synchronous, active low |
| we_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data; commands in bits 7:0 |
| wp_ni | input | 1 | Boot sector write protect, active low |
| sect_lock_i | input | 2**SECT_W | Per-sector protection |
| rdata_o | output | DATA_W | Read data or status, registered on rd_i |
| ry_by_o | output | 1 | 1 = ready, 0 = operation running |

## Verification
The tests drive correct sequences in full mode and in shortcut mode, then variants with one broken unlock step, with a wrong unlock address, and with a program that tries to raise a cleared bit. Comparing these shows whether the decoder tells valid sequences from near misses. Status reads taken with data bit 7 set and with it clear, and during an erase, separate the inverted-bit path from the toggle path. Aborts placed after the clear phase of an erase, and a pause in the middle of an erase with a program into a different sector, show the order of the erase phases and that the remaining time is kept across the pause.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_U1, ST_U2, ST_PADDR, ST_E0, ST_E1, ST_E2, ST_BEXIT, ST_BUSY, ST_FAIL
  } cmd_st_e;
  localparam logic [7:0] C_UNL1  = 8'hAA;
  localparam logic [7:0] C_UNL2  = 8'h55;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_ESET  = 8'h80;
  localparam logic [7:0] C_SERA  = 8'h30;
  localparam logic [7:0] C_CERA  = 8'h10;
  localparam logic [7:0] C_BYP   = 8'h20;
  localparam logic [7:0] C_BEXIT = 8'h90;
  localparam logic [7:0] C_SUSP  = 8'hB0;
  localparam logic [7:0] C_RST   = 8'hF0;
endpackage

// File: rtl/nor_op_timer.sv
module nor_op_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int SECT_W = 2,
  localparam int NWORD = 1 << ADDR_W,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              fill_en_i,
  input  logic [NSECT-1:0]  fill_sel_i,
  input  logic              fill_ones_i
);
  logic [DATA_W-1:0] mem_q [NWORD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NWORD; w++) mem_q[w] <= '1;
    end else begin
      for (int w = 0; w < NWORD; w++) begin
        logic [ADDR_W-1:0] wa;
        wa = ADDR_W'(w);
        if (fill_en_i && fill_sel_i[wa[ADDR_W-1 -: SECT_W]])
          mem_q[w] <= {DATA_W{fill_ones_i}};
        else if (wr_en_i && wr_addr_i == wa)
          mem_q[w] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 8,
  parameter int PRE_CYC   = 6,
  parameter int ERASE_CYC = 12,
  parameter logic [ADDR_W-1:0] UNLK_A = 'h15,
  parameter logic [ADDR_W-1:0] UNLK_B = 'h2A,
  localparam int NSECT = 1 << SECT_W,
  localparam int MAXC  = (PROG_CYC > PRE_CYC) ? ((PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC)
                                              : ((PRE_CYC > ERASE_CYC) ? PRE_CYC : ERASE_CYC),
  localparam int CNT_W = $clog2(MAXC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_reset_ni,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wp_ni,
  input  logic [NSECT-1:0]  sect_lock_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ry_by_o
);
  cmd_st_e st_q, st_d;
  logic byp_q, byp_d, susp_q, susp_d, prog_q, prog_d, eph_q, eph_d;
  logic [NSECT-1:0]  sel_q, sel_d, lock_m, one_sec;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [DATA_W-1:0] pd_q, pd_d, arr_q, stat_w;
  logic perr_q, perr_d, d7_q, d7_d, tog_q;
  logic p_ld, p_run, p_done, e_ld, e_run, e_done;
  logic [CNT_W-1:0] e_val;
  logic wr_en, fill_en, fill_ones, busy;
  logic [7:0] cmd;
  logic [SECT_W-1:0] a_sec;

  assign cmd   = wdata_i[7:0];
  assign a_sec = addr_i[ADDR_W-1 -: SECT_W];

  for (genvar s = 0; s < NSECT; s++) begin : g_lock
    assign lock_m[s]  = sect_lock_i[s] | (!wp_ni && (s >= NSECT - 2));
    assign one_sec[s] = (a_sec == SECT_W'(s));
  end

  nor_op_timer #(.CNT_W(CNT_W)) u_ptmr (
    .clk_i, .rst_ni, .clr_i(!hw_reset_ni), .load_i(p_ld),
    .load_val_i(CNT_W'(PROG_CYC)), .run_i(p_run), .done_o(p_done));

  nor_op_timer #(.CNT_W(CNT_W)) u_etmr (
    .clk_i, .rst_ni, .clr_i(!hw_reset_ni), .load_i(e_ld),
    .load_val_i(e_val), .run_i(e_run), .done_o(e_done));

  nor_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_arr (
    .clk_i, .rst_ni, .rd_addr_i(addr_i), .rd_data_o(arr_q),
    .wr_en_i(wr_en), .wr_addr_i(pa_q), .wr_data_i(pd_q),
    .fill_en_i(fill_en), .fill_sel_i(sel_q), .fill_ones_i(fill_ones));

  always_comb begin
    st_d = st_q; byp_d = byp_q; susp_d = susp_q; prog_d = prog_q; eph_d = eph_q;
    sel_d = sel_q; pa_d = pa_q; pd_d = pd_q; perr_d = perr_q; d7_d = d7_q;
    p_ld = 1'b0; p_run = 1'b0; e_ld = 1'b0; e_run = 1'b0; e_val = CNT_W'(PRE_CYC);
    wr_en = 1'b0; fill_en = 1'b0; fill_ones = 1'b0;
    unique case (st_q)
      ST_READ: if (we_i) begin
        if (byp_q) begin
          if (cmd == C_PROG)       st_d = ST_PADDR;
          else if (cmd == C_BEXIT) st_d = ST_BEXIT;
        end else if (addr_i == UNLK_A && cmd == C_UNL1) st_d = ST_U1;
        else if (susp_q && cmd == C_SERA) begin
          st_d = ST_BUSY; prog_d = 1'b0; d7_d = 1'b0;
        end
      end
      ST_U1: if (we_i) st_d = (addr_i == UNLK_B && cmd == C_UNL2) ? ST_U2 : ST_READ;
      ST_U2: if (we_i) begin
        st_d = ST_READ;
        if (addr_i == UNLK_A) begin
          if (cmd == C_PROG)                 st_d = ST_PADDR;
          else if (cmd == C_ESET && !susp_q) st_d = ST_E0;
          else if (cmd == C_BYP && !susp_q)  byp_d = 1'b1;
        end
      end
      ST_PADDR: if (we_i) begin
        st_d = ST_READ;
        if (!lock_m[a_sec] && !(susp_q && sel_q[a_sec])) begin
          st_d = ST_BUSY; prog_d = 1'b1; pa_d = addr_i; pd_d = wdata_i & arr_q;
          perr_d = |(wdata_i & ~arr_q); d7_d = ~wdata_i[7]; p_ld = 1'b1;
        end
      end
      ST_E0: if (we_i) st_d = (addr_i == UNLK_A && cmd == C_UNL1) ? ST_E1 : ST_READ;
      ST_E1: if (we_i) st_d = (addr_i == UNLK_B && cmd == C_UNL2) ? ST_E2 : ST_READ;
      ST_E2: if (we_i) begin
        st_d = ST_READ;
        sel_d = '0;
        if (cmd == C_SERA)                         sel_d = one_sec & ~lock_m;
        else if (cmd == C_CERA && addr_i == UNLK_A) sel_d = ~lock_m;
        if (sel_d != '0) begin
          st_d = ST_BUSY; prog_d = 1'b0; eph_d = 1'b0; d7_d = 1'b0; e_ld = 1'b1;
        end
      end
      ST_BEXIT: if (we_i) begin
        st_d = ST_READ;
        if (cmd == 8'h00) byp_d = 1'b0;
      end
      ST_BUSY: begin
        if (prog_q) begin
          p_run = 1'b1;
          if (p_done) begin
            if (perr_q) st_d = ST_FAIL;
            else begin wr_en = 1'b1; st_d = ST_READ; end
          end
        end else if (we_i && cmd == C_SUSP) begin
          st_d = ST_READ; susp_d = 1'b1;
        end else begin
          e_run = 1'b1;
          if (e_done) begin
            fill_en = 1'b1;
            if (!eph_q) begin
              eph_d = 1'b1; e_ld = 1'b1; e_val = CNT_W'(ERASE_CYC);
            end else begin
              fill_ones = 1'b1; st_d = ST_READ; susp_d = 1'b0; sel_d = '0;
            end
          end
        end
      end
      ST_FAIL: if (we_i && cmd == C_RST) st_d = ST_READ;
      default: st_d = ST_READ;
    endcase
    if (!hw_reset_ni) begin
      st_d = ST_READ; byp_d = 1'b0; susp_d = 1'b0; sel_d = '0;
      wr_en = 1'b0; fill_en = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_READ; byp_q <= 1'b0; susp_q <= 1'b0; prog_q <= 1'b0; eph_q <= 1'b0;
      sel_q <= '0; pa_q <= '0; pd_q <= '0; perr_q <= 1'b0; d7_q <= 1'b0;
    end else begin
      st_q <= st_d; byp_q <= byp_d; susp_q <= susp_d; prog_q <= prog_d; eph_q <= eph_d;
      sel_q <= sel_d; pa_q <= pa_d; pd_q <= pd_d; perr_q <= perr_d; d7_q <= d7_d;
    end
  end

  assign busy = (st_q == ST_BUSY) || (st_q == ST_FAIL);

  always_comb begin
    stat_w    = '0;
    stat_w[7] = d7_q;
    stat_w[6] = tog_q;
    stat_w[5] = (st_q == ST_FAIL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '1; tog_q <= 1'b0;
    end else if (rd_i) begin
      rdata_o <= busy ? stat_w : arr_q;
      if (busy) tog_q <= ~tog_q;
    end
  end

  assign ry_by_o = !busy;
endmodule

// File: rtl/nor_cmd_fsm_chk.sv
module nor_cmd_fsm_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hw_reset_ni,
  input logic              we_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              ry_by_o
);
  assert_abort_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_reset_ni |=> ry_by_o);

  assert_rdata_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  assert_status_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !ry_by_o) ##1 (rd_i && !ry_by_o) |=> (rdata_o[6] != $past(rdata_o[6])));

  assert_busy_needs_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ry_by_o) |-> $past(we_i));
endmodule

bind nor_cmd_fsm nor_cmd_fsm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hw_reset_ni(hw_reset_ni), .we_i(we_i),
  .rd_i(rd_i), .rdata_o(rdata_o), .ry_by_o(ry_by_o));

// File: tb/sim_nor_cmd_fsm.sv
module sim_nor_cmd_fsm;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_CYC = 8, PRE_CYC = 6, ERASE_CYC = 12;
  localparam logic [5:0] UA = 6'h15, UB = 6'h2A;

  logic clk = 1'b0, rst_ni = 1'b0, hw_reset_ni = 1'b1, we_i = 1'b0, rd_i = 1'b0, wp_ni = 1'b1;
  logic [5:0]  addr_i = '0;
  logic [15:0] wdata_i = '0, rdata_o;
  logic [3:0]  sect_lock_i = '0;
  logic        ry_by_o;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_fsm u0 (
    .clk_i(clk), .rst_ni, .hw_reset_ni, .we_i, .rd_i, .addr_i, .wdata_i,
    .wp_ni, .sect_lock_i, .rdata_o, .ry_by_o);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [15:0] d);
    rd_i = 1'b1; addr_i = a;
    @(posedge clk); @(negedge clk);
    rd_i = 1'b0; d = rdata_o;
  endtask

  task automatic do_prog(input logic [5:0] a, input logic [15:0] d);
    bus_wr(UA, 16'hAA); bus_wr(UB, 16'h55); bus_wr(UA, 16'hA0); bus_wr(a, d);
  endtask

  task automatic do_erase(input logic [5:0] a, input logic [7:0] c);
    bus_wr(UA, 16'hAA); bus_wr(UB, 16'h55); bus_wr(UA, 16'h80);
    bus_wr(UA, 16'hAA); bus_wr(UB, 16'h55); bus_wr(a, {8'h00, c});
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ry_by_o && n < 500) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R1 ready", 16'(ry_by_o), 16'd1);
    bus_rd(6'h00, d); check("R1 erased word", d, 16'hFFFF);
    bus_rd(6'h3F, d); check("R1 erased last word", d, 16'hFFFF);
  endtask

  task automatic t_program;
    logic [15:0] d; int n;
    do_prog(6'h05, 16'h1234);
    wait_ready(n); check("R6 program busy cycles", 16'(n), 16'(PROG_CYC));
    bus_rd(6'h05, d); check("R2 programmed word", d, 16'h1234);
    do_prog(6'h05, 16'h1230);
    wait_ready(n); bus_rd(6'h05, d); check("R2 clear-only update", d, 16'h1230);
  endtask

  task automatic t_status;
    logic [15:0] d1, d2; int n;
    do_prog(6'h06, 16'h0055);
    bus_rd(6'h06, d1); bus_rd(6'h06, d2);
    check("R4 inverted bit7", 16'(d1[7]), 16'd1);
    check("R5 bit6 toggles", 16'(d1[6] ^ d2[6]), 16'd1);
    check("R5 unused status bits", d1 & 16'hFF1F, 16'h0000);
    check("R13 no error bit early", 16'(d1[5]), 16'd0);
    wait_ready(n); bus_rd(6'h06, d1); check("R2 word after polling", d1, 16'h0055);
  endtask

  task automatic t_erase;
    logic [15:0] d; int n;
    do_prog(6'h12, 16'h00F0); wait_ready(n);
    do_erase(6'h03, 8'h30);
    bus_rd(6'h00, d); check("R4 erase bit7 low", 16'(d[7]), 16'd0);
    wait_ready(n); check("R6 erase busy cycles", 16'(n), 16'(PRE_CYC + ERASE_CYC - 1));
    bus_rd(6'h05, d); check("R8 sector erased", d, 16'hFFFF);
    bus_rd(6'h06, d); check("R8 sector erased 2", d, 16'hFFFF);
    bus_rd(6'h12, d); check("R8 other sector kept", d, 16'h00F0);
  endtask

  task automatic t_bypass;
    logic [15:0] d; int n;
    bus_wr(UA, 16'hAA); bus_wr(UB, 16'h55); bus_wr(UA, 16'h20);
    bus_wr(6'h00, 16'hA0); bus_wr(6'h03, 16'hABCD);
    wait_ready(n); check("R3 bypass busy", 16'(n), 16'(PROG_CYC));
    bus_rd(6'h03, d); check("R3 bypass program", d, 16'hABCD);
    bus_wr(6'h2F, 16'hA0); bus_wr(6'h04, 16'h1111);
    wait_ready(n); bus_rd(6'h04, d); check("R3 second bypass program", d, 16'h1111);
    bus_wr(6'h00, 16'h90); bus_wr(6'h00, 16'h00);
    bus_wr(6'h00, 16'hA0); bus_wr(6'h07, 16'h0000);
    check("R3 after exit stays ready", 16'(ry_by_o), 16'd1);
    bus_rd(6'h07, d); check("R3 after exit no program", d, 16'hFFFF);
  endtask

  task automatic t_invalid;
    logic [15:0] d;
    bus_wr(UA, 16'hAA); bus_wr(UB, 16'h56); bus_wr(UA, 16'hA0); bus_wr(6'h08, 16'h0000);
    check("R12 bad data ready", 16'(ry_by_o), 16'd1);
    bus_rd(6'h08, d); check("R12 bad data no effect", d, 16'hFFFF);
    bus_wr(UA, 16'hAA); bus_wr(UA, 16'h55); bus_wr(UA, 16'hA0); bus_wr(6'h09, 16'h0000);
    check("R12 bad address ready", 16'(ry_by_o), 16'd1);
    bus_rd(6'h09, d); check("R12 bad address no effect", d, 16'hFFFF);
  endtask

  task automatic t_error;
    logic [15:0] d;
    do_prog(6'h03, 16'hFFFF);
    repeat (PROG_CYC + 3) @(negedge clk);
    check("R13 stays busy", 16'(ry_by_o), 16'd0);
    bus_rd(6'h03, d); check("R13 error bit", 16'(d[5]), 16'd1);
    bus_wr(6'h00, 16'h00F0);
    check("R13 reset command releases", 16'(ry_by_o), 16'd1);
    bus_rd(6'h03, d); check("R13 word unchanged", d, 16'hABCD);
  endtask

  task automatic t_protect;
    logic [15:0] d; int n;
    wp_ni = 1'b0;
    do_prog(6'h30, 16'h0000);
    check("R11 boot program ignored", 16'(ry_by_o), 16'd1);
    do_erase(6'h24, 8'h30);
    check("R11 boot erase ignored", 16'(ry_by_o), 16'd1);
    bus_rd(6'h30, d); check("R11 boot word kept", d, 16'hFFFF);
    wp_ni = 1'b1; sect_lock_i = 4'b0010;
    do_prog(6'h11, 16'h0000);
    check("R11 locked sector ignored", 16'(ry_by_o), 16'd1);
    bus_rd(6'h11, d); check("R11 locked word kept", d, 16'hFFFF);
    sect_lock_i = 4'b0000;
    do_prog(6'h30, 16'h0F0F); wait_ready(n);
    bus_rd(6'h30, d); check("R11 boot unlocked program", d, 16'h0F0F);
  endtask

  task automatic t_abort;
    logic [15:0] d; int n;
    do_prog(6'h0A, 16'h0000);
    repeat (2) @(negedge clk);
    hw_reset_ni = 1'b0; @(negedge clk);
    check("R7 ready after abort", 16'(ry_by_o), 16'd1);
    hw_reset_ni = 1'b1;
    bus_rd(6'h0A, d); check("R7 aborted word unchanged", d, 16'hFFFF);
    do_prog(6'h0A, 16'h00FF); wait_ready(n);
    bus_rd(6'h0A, d); check("R7 program after abort", d, 16'h00FF);
  endtask

  task automatic t_preprog;
    logic [15:0] d;
    do_erase(6'h1C, 8'h30);
    repeat (PRE_CYC + 1) @(negedge clk);
    hw_reset_ni = 1'b0; @(negedge clk); hw_reset_ni = 1'b1;
    bus_rd(6'h1F, d); check("R9 cleared before erase", d, 16'h0000);
    bus_rd(6'h12, d); check("R9 cleared before erase 2", d, 16'h0000);
  endtask

  task automatic t_suspend;
    logic [15:0] d; int n;
    do_erase(6'h10, 8'h30);
    repeat (3) @(negedge clk);
    bus_wr(6'h00, 16'h00B0);
    check("R10 ready when paused", 16'(ry_by_o), 16'd1);
    bus_rd(6'h0A, d); check("R10 read other sector", d, 16'h00FF);
    do_prog(6'h21, 16'h5A5A); wait_ready(n);
    bus_rd(6'h21, d); check("R10 program while paused", d, 16'h5A5A);
    do_prog(6'h13, 16'h0000);
    check("R10 program into erasing sector ignored", 16'(ry_by_o), 16'd1);
    bus_wr(6'h00, 16'h0030);
    wait_ready(n); check("R10 remaining cycles", 16'(n), 16'(PRE_CYC + ERASE_CYC - 3));
    bus_rd(6'h13, d); check("R10 erase completes", d, 16'hFFFF);
    bus_rd(6'h21, d); check("R10 paused program kept", d, 16'h5A5A);
  endtask

  task automatic t_chip;
    logic [15:0] d; int n;
    sect_lock_i = 4'b1000;
    do_erase(UA, 8'h10);
    wait_ready(n);
    bus_rd(6'h0A, d); check("R8 chip erase sector0", d, 16'hFFFF);
    bus_rd(6'h21, d); check("R8 chip erase sector2", d, 16'hFFFF);
    bus_rd(6'h30, d); check("R8 chip erase skips locked", d, 16'h0F0F);
    sect_lock_i = 4'b0000;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_status();
    t_erase();
    t_bypass();
    t_invalid();
    t_error();
    t_protect();
    t_abort();
    t_preprog();
    t_suspend();
    t_chip();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule